// File: doc/BRIEF.md
# Debug Address Comparator Bank

This block holds a set of hardware debug comparator slots for one processor. Each slot pairs a 32-bit value register with a 32-bit control register. Breakpoint slots watch instruction fetch addresses and watchpoint slots watch data load and store addresses. A slot hits when all of these agree: its enable bit, the privilege of the access, the access kind (watchpoints only), a masked address compare and a byte-select bitmap indexed by the low address bits. A breakpoint slot can also run inverted, so that it hits on every fetch that does not match its programmed address. Single-stepping relies on this mode.

Software programs the slots through a plain write and read port. The fetch side and the data side each deliver an address with a valid strobe. One cycle after the strobe the block presents a registered per-slot hit vector for each side. It also presents the lowest-numbered hitting slot and an any-hit flag. A cycle with no strobe yields an all-zero result in the following cycle. What happens after a hit, such as exception entry or handler work, belongs to other blocks.

Top module: `dbg_cmp_bank`

## Requirements
- R1: Control bit 0 is the slot enable. A slot whose enable bit is clear never reports a hit. Register select `cfg_sel` is {kind[1:0], index[3:0]}, with kind 0 = breakpoint value, 1 = breakpoint control, 2 = watchpoint value, 3 = watchpoint control.
- R2: A breakpoint slot matches when the fetch address with bits [1:0] cleared equals its value register and the byte-select bit numbered by fetch address bits [1:0] is set. Byte select is control bits [12:5].
- R3: A watchpoint slot uses a 3-bit alignment mask when any byte-select bit [7:4] is set, and a 2-bit mask otherwise. The address with the masked bits cleared must equal the value register, and the byte-select bit numbered by the masked-off bits must be set.
- R4: Watchpoint access kind is filtered by control bit 3 (loads) and control bit 4 (stores). With both bits set, either kind can hit. A read never hits a store-only slot, and a write never hits a load-only slot.
- R5: Control bit 1 permits user accesses and control bit 2 permits privileged accesses. A slot hits only if the bit for the current privilege level is set (`*_priv` = 1 means privileged).
- R6: When control bit 22 is set on a breakpoint slot, the slot hits on an enabled, privilege-permitted fetch only when the R2 match fails.
- R7: Hit vectors are registered one cycle after the valid strobe of their side. A cycle without a strobe gives all-zero hits in the next cycle.
- R8: `*_idx` is the lowest-numbered hitting slot and `*_any` flags any hit. When there is no hit, both are 0.
- R9: A register write lands at the clock edge. A fetch or access in the same cycle as the write still sees the old value, and later cycles see the new one. `cfg_rdata` returns the selected register combinationally, and 0 for an index beyond the slot count.
- R10: After reset, all registers read 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 6 | Register select {kind, index} |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_sel |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 32 | Fetch address |
| fetch_priv | input | 1 | Fetch is privileged |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 32 | Data access address |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_priv | input | 1 | Access is privileged |
| bkpt_hit | output | NUM_BKPT | Per-slot breakpoint hits |
| bkpt_idx | output | BIW | Lowest hitting breakpoint slot |
| bkpt_any | output | 1 | Any breakpoint hit |
| wtch_hit | output | NUM_WTCH | Per-slot watchpoint hits |
| wtch_idx | output | WIW | Lowest hitting watchpoint slot |
| wtch_any | output | 1 | Any watchpoint hit |

## Verification
The assertions check the following on every cycle:
- a hit is always preceded by a strobe on its side;
- a slot that was disabled in the previous cycle never hits;
- the reported index is the lowest set bit of the hit vector;
- the any flag agrees with the vector.

The bench scenarios cover everything that depends on programmed contents:
- the masked compare and byte-select decoding at each alignment width;
- access-kind and privilege filtering;
- inverted matching;
- the old-value behaviour when a write and a fetch share a cycle.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;
    localparam int DW        = 32;
    localparam int IDX_W     = 4;
    localparam int SEL_W     = IDX_W + 2;
    localparam int C_EN      = 0;
    localparam int C_USER    = 1;
    localparam int C_PRIV    = 2;
    localparam int C_LOAD    = 3;
    localparam int C_STORE   = 4;
    localparam int C_BSEL_LO = 5;
    localparam int BSEL_W    = 8;
    localparam int C_INVERT  = 22;

    typedef enum logic [1:0] {
        RK_BVAL = 2'd0,
        RK_BCTL = 2'd1,
        RK_WVAL = 2'd2,
        RK_WCTL = 2'd3
    } reg_kind_e;

    function automatic logic [BSEL_W-1:0] bsel_of(input logic [DW-1:0] c);
        return c[C_BSEL_LO +: BSEL_W];
    endfunction

    function automatic logic priv_ok(input logic [DW-1:0] c, input logic p);
        return p ? c[C_PRIV] : c[C_USER];
    endfunction
endpackage

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
    import dbg_cmp_pkg::*;
#(
    parameter bit IS_WATCH = 1'b0
) (
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] ctl,
    input  logic [DW-1:0] addr,
    input  logic          write,
    input  logic          priv,
    output logic          hit
);
    logic [BSEL_W-1:0] bsel;
    logic              gate;

    always_comb begin
        bsel = bsel_of(ctl);
        gate = ctl[C_EN] & priv_ok(ctl, priv);
    end

    generate
        if (IS_WATCH) begin : g_watch
            logic [2:0]    off;
            logic [DW-1:0] base;
            logic          wide, kind_ok;
            always_comb begin
                wide    = |bsel[7:4];
                off     = wide ? addr[2:0] : {1'b0, addr[1:0]};
                base    = wide ? {addr[DW-1:3], 3'b000} : {addr[DW-1:2], 2'b00};
                kind_ok = write ? ctl[C_STORE] : ctl[C_LOAD];
                hit     = gate & kind_ok & (base == val) & bsel[off];
            end
        end else begin : g_fetch
            logic same;
            always_comb begin
                same = ({addr[DW-1:2], 2'b00} == val) & bsel[{1'b0, addr[1:0]}];
                hit  = gate & (ctl[C_INVERT] ? ~same : same);
            end
        end
    endgenerate
endmodule

// File: rtl/dbg_prio_enc.sv
module dbg_prio_enc #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
    import dbg_cmp_pkg::*;
#(
    parameter int NUM_BKPT = 6,
    parameter int NUM_WTCH = 4,
    localparam int BIW = (NUM_BKPT > 1) ? $clog2(NUM_BKPT) : 1,
    localparam int WIW = (NUM_WTCH > 1) ? $clog2(NUM_WTCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [DW-1:0]       cfg_wdata,
    output logic [DW-1:0]       cfg_rdata,
    input  logic                fetch_valid,
    input  logic [DW-1:0]       fetch_addr,
    input  logic                fetch_priv,
    input  logic                acc_valid,
    input  logic [DW-1:0]       acc_addr,
    input  logic                acc_write,
    input  logic                acc_priv,
    output logic [NUM_BKPT-1:0] bkpt_hit,
    output logic [BIW-1:0]      bkpt_idx,
    output logic                bkpt_any,
    output logic [NUM_WTCH-1:0] wtch_hit,
    output logic [WIW-1:0]      wtch_idx,
    output logic                wtch_any
);
    reg_kind_e         kind;
    logic [IDX_W-1:0]  slot;
    logic [DW-1:0]     bval_q [NUM_BKPT];
    logic [DW-1:0]     bctl_q [NUM_BKPT];
    logic [DW-1:0]     wval_q [NUM_WTCH];
    logic [DW-1:0]     wctl_q [NUM_WTCH];
    logic [NUM_BKPT-1:0] bhit_c, bkpt_en;
    logic [NUM_WTCH-1:0] whit_c, wtch_en;
    logic [BIW-1:0]    bidx_c;
    logic [WIW-1:0]    widx_c;
    logic              bany_c, wany_c;

    always_comb begin
        kind = reg_kind_e'(cfg_sel[SEL_W-1:IDX_W]);
        slot = cfg_sel[IDX_W-1:0];
    end

    generate
        for (genvar i = 0; i < NUM_BKPT; i++) begin : g_bk
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bval_q[i] <= '0;
                    bctl_q[i] <= '0;
                end else if (cfg_we && int'(slot) == i) begin
                    if (kind == RK_BVAL) bval_q[i] <= cfg_wdata;
                    if (kind == RK_BCTL) bctl_q[i] <= cfg_wdata;
                end
            end
            assign bkpt_en[i] = bctl_q[i][C_EN];
            dbg_slot_match #(.IS_WATCH(1'b0)) u_bm (
                .val(bval_q[i]), .ctl(bctl_q[i]), .addr(fetch_addr),
                .write(1'b0), .priv(fetch_priv), .hit(bhit_c[i])
            );
        end
        for (genvar j = 0; j < NUM_WTCH; j++) begin : g_wt
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wval_q[j] <= '0;
                    wctl_q[j] <= '0;
                end else if (cfg_we && int'(slot) == j) begin
                    if (kind == RK_WVAL) wval_q[j] <= cfg_wdata;
                    if (kind == RK_WCTL) wctl_q[j] <= cfg_wdata;
                end
            end
            assign wtch_en[j] = wctl_q[j][C_EN];
            dbg_slot_match #(.IS_WATCH(1'b1)) u_wm (
                .val(wval_q[j]), .ctl(wctl_q[j]), .addr(acc_addr),
                .write(acc_write), .priv(acc_priv), .hit(whit_c[j])
            );
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        unique case (kind)
            RK_BVAL: for (int i = 0; i < NUM_BKPT; i++) if (int'(slot) == i) cfg_rdata = bval_q[i];
            RK_BCTL: for (int i = 0; i < NUM_BKPT; i++) if (int'(slot) == i) cfg_rdata = bctl_q[i];
            RK_WVAL: for (int i = 0; i < NUM_WTCH; i++) if (int'(slot) == i) cfg_rdata = wval_q[i];
            RK_WCTL: for (int i = 0; i < NUM_WTCH; i++) if (int'(slot) == i) cfg_rdata = wctl_q[i];
        endcase
    end

    dbg_prio_enc #(.N(NUM_BKPT), .IW(BIW)) u_bpe (.req(bhit_c), .idx(bidx_c), .any(bany_c));
    dbg_prio_enc #(.N(NUM_WTCH), .IW(WIW)) u_wpe (.req(whit_c), .idx(widx_c), .any(wany_c));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bkpt_hit <= '0;
            bkpt_idx <= '0;
            bkpt_any <= 1'b0;
            wtch_hit <= '0;
            wtch_idx <= '0;
            wtch_any <= 1'b0;
        end else begin
            bkpt_hit <= fetch_valid ? bhit_c : '0;
            bkpt_idx <= fetch_valid ? bidx_c : '0;
            bkpt_any <= fetch_valid & bany_c;
            wtch_hit <= acc_valid ? whit_c : '0;
            wtch_idx <= acc_valid ? widx_c : '0;
            wtch_any <= acc_valid & wany_c;
        end
    end
endmodule

// File: rtl/dbg_cmp_bank_chk.sv
module dbg_cmp_bank_chk #(
    parameter int NB  = 6,
    parameter int NW  = 4,
    parameter int BIW = 3,
    parameter int WIW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_valid,
    input logic          acc_valid,
    input logic [NB-1:0] bkpt_hit,
    input logic [BIW-1:0] bkpt_idx,
    input logic          bkpt_any,
    input logic [NW-1:0] wtch_hit,
    input logic [WIW-1:0] wtch_idx,
    input logic          wtch_any,
    input logic [NB-1:0] bkpt_en,
    input logic [NW-1:0] wtch_en
);
    logic [NB-1:0] blow;
    logic [NW-1:0] wlow;
    always_comb begin
        blow = (NB'(1) << bkpt_idx) - NB'(1);
        wlow = (NW'(1) << wtch_idx) - NW'(1);
    end

    p_bhit_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_hit != '0) |-> $past(fetch_valid));
    p_whit_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wtch_hit != '0) |-> $past(acc_valid));
    p_bany_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_any == (bkpt_hit != '0));
    p_wany_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wtch_any == (wtch_hit != '0));
    p_bidx_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_any |-> (bkpt_hit[bkpt_idx] && ((bkpt_hit & blow) == '0)));
    p_widx_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wtch_any |-> (wtch_hit[wtch_idx] && ((wtch_hit & wlow) == '0)));

    generate
        for (genvar i = 0; i < NB; i++) begin : g_b
            p_bdisabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
                bkpt_hit[i] |-> $past(bkpt_en[i]));
        end
        for (genvar j = 0; j < NW; j++) begin : g_w
            p_wdisabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
                wtch_hit[j] |-> $past(wtch_en[j]));
        end
    endgenerate
endmodule

bind dbg_cmp_bank dbg_cmp_bank_chk #(
    .NB(NUM_BKPT), .NW(NUM_WTCH), .BIW(BIW), .WIW(WIW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .acc_valid(acc_valid),
    .bkpt_hit(bkpt_hit), .bkpt_idx(bkpt_idx), .bkpt_any(bkpt_any),
    .wtch_hit(wtch_hit), .wtch_idx(wtch_idx), .wtch_any(wtch_any),
    .bkpt_en(bkpt_en), .wtch_en(wtch_en)
);

// File: tb/dbg_cmp_bank_test.sv
module dbg_cmp_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        fetch_valid = 1'b0, fetch_priv = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [5:0]  bkpt_hit;
    logic [2:0]  bkpt_idx;
    logic        bkpt_any;
    logic [3:0]  wtch_hit;
    logic [1:0]  wtch_idx;
    logic        wtch_any;
    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbg_cmp_bank uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_priv(fetch_priv),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
        .bkpt_hit(bkpt_hit), .bkpt_idx(bkpt_idx), .bkpt_any(bkpt_any),
        .wtch_hit(wtch_hit), .wtch_idx(wtch_idx), .wtch_any(wtch_any)
    );

    // Row layout: {is_watch, write, priv, expected hits[7:0], address[31:0]}
    localparam int NV = 17;
    localparam logic [42:0] VECS [NV] = '{
        {1'b0,1'b0,1'b0,8'h11,32'h0000_1000},  // R2 R6 R5
        {1'b0,1'b0,1'b1,8'h05,32'h0000_1000},  // R5
        {1'b0,1'b0,1'b1,8'h01,32'h0000_1002},  // R2
        {1'b0,1'b0,1'b0,8'h12,32'h0000_2002},  // R2
        {1'b0,1'b0,1'b0,8'h10,32'h0000_2000},  // R2 byte select
        {1'b0,1'b0,1'b0,8'h00,32'h0000_3000},  // R6 matched
        {1'b0,1'b0,1'b0,8'h00,32'h0000_3002},  // R6 matched
        {1'b0,1'b0,1'b1,8'h20,32'h0000_4003},  // R8
        {1'b0,1'b0,1'b0,8'h10,32'h0000_1004},  // R6
        {1'b1,1'b0,1'b0,8'h01,32'h0000_8000},  // R3
        {1'b1,1'b1,1'b0,8'h03,32'h0000_8006},  // R3 R4
        {1'b1,1'b0,1'b0,8'h01,32'h0000_8006},  // R4
        {1'b1,1'b1,1'b1,8'h09,32'h0000_8003},  // R5
        {1'b1,1'b0,1'b1,8'h04,32'h0000_9001},  // R3
        {1'b1,1'b1,1'b1,8'h00,32'h0000_9001},  // R4
        {1'b1,1'b0,1'b0,8'h00,32'h0000_9000},  // R3
        {1'b1,1'b0,1'b0,8'h00,32'h0000_8008}   // R3
    };

    function automatic logic [31:0] ctl(input bit en, input bit usr, input bit prv,
                                        input bit ld, input bit st,
                                        input logic [7:0] sel, input bit inv);
        return (32'(inv) << 22) | (32'(sel) << 5) | (32'(st) << 4) | (32'(ld) << 3)
             | (32'(prv) << 2) | (32'(usr) << 1) | 32'(en);
    endfunction

    function automatic int lowest(input logic [7:0] v);
        for (int k = 7; k >= 0; k--) if (v[k]) lowest = k;
        if (v == 0) lowest = 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int i, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = {k, 4'(i)}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 bkpt_hit", 32'(bkpt_hit), 0);
        check("R10 wtch_hit", 32'(wtch_hit), 0);
        cfg_sel = {2'd1, 4'd0}; #1;
        check("R10 readback", cfg_rdata, 0);

        wr(0, 0, 32'h1000); wr(1, 0, ctl(1,1,1,0,0,8'h0F,0));
        wr(0, 1, 32'h2000); wr(1, 1, ctl(1,1,0,0,0,8'h0C,0));
        wr(0, 2, 32'h1000); wr(1, 2, ctl(1,0,1,0,0,8'h03,0));
        wr(0, 3, 32'h1000); wr(1, 3, ctl(0,1,1,0,0,8'h0F,0));
        wr(0, 4, 32'h3000); wr(1, 4, ctl(1,1,0,0,0,8'h0F,1));
        wr(0, 5, 32'h4000); wr(1, 5, ctl(1,1,1,0,0,8'h0F,0));
        wr(2, 0, 32'h8000); wr(3, 0, ctl(1,1,1,1,1,8'hFF,0));
        wr(2, 1, 32'h8004); wr(3, 1, ctl(1,1,0,0,1,8'h0F,0));
        wr(2, 2, 32'h9000); wr(3, 2, ctl(1,1,1,1,0,8'h02,0));
        wr(2, 3, 32'h8000); wr(3, 3, ctl(1,0,1,1,1,8'h0F,0));

        // R9 readback
        @(negedge clk);
        cfg_sel = {2'd2, 4'd1}; #1;
        check("R9 readback wval", cfg_rdata, 32'h8004);
        cfg_sel = {2'd1, 4'd9}; #1;
        check("R9 readback out of range", cfg_rdata, 0);

        for (int r = 0; r < NV; r++) begin
            logic [42:0] v;
            logic [7:0]  e;
            v = VECS[r];
            e = v[39:32];
            @(negedge clk);
            if (v[42]) begin
                acc_valid = 1'b1; acc_write = v[41]; acc_priv = v[40]; acc_addr = v[31:0];
            end else begin
                fetch_valid = 1'b1; fetch_priv = v[40]; fetch_addr = v[31:0];
            end
            @(negedge clk);
            acc_valid = 1'b0; fetch_valid = 1'b0;
            if (v[42]) begin
                check("R2-table wtch_hit (R3 R4 R5)", 32'(wtch_hit), 32'(e[3:0]));
                check("R8 wtch_idx", 32'(wtch_idx), 32'(lowest(e)));
                check("R8 wtch_any", 32'(wtch_any), 32'(e != 0));
            end else begin
                check("R2 R5 R6 bkpt_hit", 32'(bkpt_hit), 32'(e[5:0]));
                check("R8 bkpt_idx", 32'(bkpt_idx), 32'(lowest(e)));
                check("R8 bkpt_any", 32'(bkpt_any), 32'(e != 0));
            end
            @(negedge clk);
            check("R7 idle gives zero", 32'({bkpt_hit, wtch_hit}), 0);
        end

        // R9: write in the same cycle as a fetch; old value still used
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = {2'd1, 4'd5}; cfg_wdata = 32'h0;
        fetch_valid = 1'b1; fetch_priv = 1'b1; fetch_addr = 32'h4000;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 same-cycle old value", 32'(bkpt_hit), 32'h20);
        @(negedge clk);
        fetch_valid = 1'b0;
        check("R9 new value next cycle R1", 32'(bkpt_hit), 32'h00);
        cfg_sel = {2'd1, 4'd5}; #1;
        check("R9 readback ctl", cfg_rdata, 0);

        // R1: disabling a watchpoint silences it
        wr(3, 0, ctl(0,1,1,1,1,8'hFF,0));
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_priv = 1'b0; acc_addr = 32'h8000;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R1 disabled watchpoint", 32'(wtch_hit), 0);

        finish_up();
    end
endmodule